// File: doc/BRIEF.md
# Chopper and Segment-Rotation Sequencer

This block generates the timing controls for a chopper-stabilised charge converter. It counts sample-period strobes and produces three outputs. The first is a 3-bit index that rotates through the eight unit segments of a current DAC. The second is a one-cycle pulse that tells the DAC's divider segments to rotate. The third is a chop sign that flips the polarity of the converter's input and output, so that the offset voltage averages out.

A single programmable interval N (1..7 sample periods) sets the rate of segment rotation. The chop interval is nested inside it: the sign flips every 2^k·N sample periods, with k set from 1 to 7. Two override modes are available for test and for external control. In one, the chop sign is taken straight from an input pin. In the other, the segment index is forced from a control field while the internal rotation keeps running underneath.

Top module: `chop_seq_top`

## Requirements
- R1: With the cycle setting `cyc_sel` at 0, no rotation happens: the internal segment index holds and `div_rotate` stays low.
- R2: With `cyc_sel` = N in 1..7, the internal segment index advances by one on every Nth `fs_tick`. The new index is visible right after the clock edge that samples that Nth tick.
- R3: The segment index wraps from 7 back to 0.
- R4: When `div_cyc_en` is 1, `div_rotate` is high for exactly one cycle, in the same cycle as each segment advance. When `div_cyc_en` is 0, it never goes high.
- R5: With `chop_sel` = k in 1..7, the internal sign toggles once every 2^k·N sample periods and starts at 0 after reset. A sign of 0 means non-inverted input and output; a sign of 1 means both are inverted.
- R6: With `chop_sel` = 0, `chop_sign` follows `ext_sign_in` in the same cycle, and the internal sign holds its value.
- R7: With internal chopping selected and `cyc_sel` = 0, the chop sign holds its current value.
- R8: With `ext_seg_en` = 1, `seg_idx` equals `ext_seg_idx`, and the internal rotation keeps counting underneath. When `ext_seg_en` returns to 0, `seg_idx` shows the internal index again.
- R9: Synchronous reset clears the period counter, the chop counter, the segment index, the internal sign and `div_rotate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_tick | input | 1 | One-cycle strobe per sample period |
| cyc_sel | input | 3 | Rotation interval N; 0 disables rotation |
| div_cyc_en | input | 1 | Enables divider-segment rotate pulses |
| chop_sel | input | 3 | Chop exponent k; 0 selects the external sign |
| ext_sign_in | input | 1 | External chop sign |
| ext_seg_en | input | 1 | Forces the segment index from `ext_seg_idx` |
| ext_seg_idx | input | 3 | Forced segment index |
| seg_idx | output | 3 | Current segment index |
| div_rotate | output | 1 | Divider-rotate pulse |
| chop_sign | output | 1 | Chop sign (1 = inverted) |

## Verification
The main function is driven through a range of (N, k) pairs and tick counts.
- Pairs with N = 1 expose off-by-one errors in the period counter.
- Larger N with small k separates the nested chop interval from the plain rotation interval.
- k = 7 runs long enough to show wrap and toggle together.
- One pattern uses N = 0 and one uses external chopping with the external pin high.

Directed tests then cover three cases on the way into and out of a mode: a sign frozen by N = 0, a forced segment index, and the 7-to-0 wrap.

// File: rtl/chop_seq_pkg.sv
package chop_seq_pkg;

    localparam int SEL_W_DEF   = 3;
    localparam int SEG_NUM_DEF = 8;

    // Terminal count of the chop counter for exponent k: 2^k - 1
    function automatic int unsigned chop_terminal(input int unsigned k);
        return (32'd1 << k) - 32'd1;
    endfunction

    // Terminal count of the period counter for interval n (n >= 1)
    function automatic int unsigned period_terminal(input int unsigned n);
        return (n == 0) ? 0 : n - 1;
    endfunction

    typedef enum logic [1:0] {
        CHOP_EXTERNAL = 2'd0,
        CHOP_INTERNAL = 2'd1
    } chop_src_e;

endpackage

// File: rtl/chop_period_div.sv
module chop_period_div #(
    parameter int SEL_W = chop_seq_pkg::SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fs_tick,
    input  logic [SEL_W-1:0] cyc_sel,
    output logic             rot_evt
);
    import chop_seq_pkg::*;

    localparam int unsigned MAX_N = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] pcnt_q;
    logic             at_term;
    logic             running;

    assign running = (cyc_sel != '0);
    assign at_term = (32'(pcnt_q) >= period_terminal(32'(cyc_sel)));
    assign rot_evt = running && fs_tick && at_term;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (!running) begin
            pcnt_q <= '0;
        end else if (fs_tick) begin
            if (at_term) pcnt_q <= '0;
            else         pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(pcnt_q) < MAX_N);

    // R1
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_sel == '0) |=> (pcnt_q == '0));

endmodule

// File: rtl/chop_seg_rotor.sv
module chop_seg_rotor #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] seg_q
);
    localparam logic [IDX_W-1:0] LAST = '1;

    always_ff @(posedge clk) begin
        if (rst)      seg_q <= '0;
        else if (adv) seg_q <= (seg_q == LAST) ? '0 : seg_q + 1'b1;
    end

    // R3
    seg_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && seg_q == LAST) |=> (seg_q == '0));

    // R1
    seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(seg_q));

endmodule

// File: rtl/chop_sign_gen.sv
module chop_sign_gen #(
    parameter int SEL_W = chop_seq_pkg::SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rot_evt,
    input  logic [SEL_W-1:0] chop_sel,
    output logic             sign_q
);
    import chop_seq_pkg::*;

    localparam int CNT_W = (1 << SEL_W) - 1;

    chop_src_e        src;
    logic [CNT_W-1:0] ccnt_q;
    logic             at_term;

    assign src     = (chop_sel == '0) ? CHOP_EXTERNAL : CHOP_INTERNAL;
    assign at_term = (32'(ccnt_q) >= chop_terminal(32'(chop_sel)));

    always_ff @(posedge clk) begin
        if (rst) begin
            ccnt_q <= '0;
            sign_q <= 1'b0;
        end else if (src == CHOP_EXTERNAL) begin
            ccnt_q <= '0;
        end else if (rot_evt) begin
            if (at_term) begin
                ccnt_q <= '0;
                sign_q <= ~sign_q;
            end else begin
                ccnt_q <= ccnt_q + 1'b1;
            end
        end
    end

    // R6
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(chop_sel) == '0) |-> $stable(sign_q));

    // R7
    no_rot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rot_evt |=> (sign_q == $past(sign_q)));

endmodule

// File: rtl/chop_seq_top.sv
module chop_seq_top #(
    parameter int SEL_W   = chop_seq_pkg::SEL_W_DEF,
    parameter int SEG_NUM = chop_seq_pkg::SEG_NUM_DEF,
    parameter int IDX_W   = $clog2(SEG_NUM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fs_tick,
    input  logic [SEL_W-1:0] cyc_sel,
    input  logic             div_cyc_en,
    input  logic [SEL_W-1:0] chop_sel,
    input  logic             ext_sign_in,
    input  logic             ext_seg_en,
    input  logic [IDX_W-1:0] ext_seg_idx,
    output logic [IDX_W-1:0] seg_idx,
    output logic             div_rotate,
    output logic             chop_sign
);
    logic             rot_evt;
    logic [IDX_W-1:0] seg_int;
    logic             sign_int;
    logic             div_q;

    chop_period_div #(.SEL_W(SEL_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .fs_tick (fs_tick),
        .cyc_sel (cyc_sel),
        .rot_evt (rot_evt)
    );

    chop_seg_rotor #(.IDX_W(IDX_W)) u_rot (
        .clk   (clk),
        .rst   (rst),
        .adv   (rot_evt),
        .seg_q (seg_int)
    );

    chop_sign_gen #(.SEL_W(SEL_W)) u_sign (
        .clk      (clk),
        .rst      (rst),
        .rot_evt  (rot_evt),
        .chop_sel (chop_sel),
        .sign_q   (sign_int)
    );

    always_ff @(posedge clk) begin
        if (rst) div_q <= 1'b0;
        else     div_q <= rot_evt && div_cyc_en;
    end

    assign div_rotate = div_q;
    assign seg_idx    = ext_seg_en ? ext_seg_idx : seg_int;
    assign chop_sign  = (chop_sel == '0) ? ext_sign_in : sign_int;

    // R4
    div_gate_chk: assert property (@(posedge clk) disable iff (rst)
        div_rotate |-> $past(div_cyc_en));

    // R1
    div_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cyc_sel) == '0) |-> !div_rotate);

    // R4
    div_with_adv_chk: assert property (@(posedge clk) disable iff (rst)
        div_rotate |-> (seg_int != $past(seg_int)));

endmodule

// File: tb/chop_seq_top_tb.sv
module chop_seq_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       fs_tick;
    logic [2:0] cyc_sel;
    logic       div_cyc_en;
    logic [2:0] chop_sel;
    logic       ext_sign_in;
    logic       ext_seg_en;
    logic [2:0] ext_seg_idx;
    logic [2:0] seg_idx;
    logic       div_rotate;
    logic       chop_sign;

    int n_checks = 0;
    int n_fail   = 0;
    int div_seen = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    chop_seq_top u_dut (
        .clk(clk), .rst(rst), .fs_tick(fs_tick), .cyc_sel(cyc_sel),
        .div_cyc_en(div_cyc_en), .chop_sel(chop_sel), .ext_sign_in(ext_sign_in),
        .ext_seg_en(ext_seg_en), .ext_seg_idx(ext_seg_idx),
        .seg_idx(seg_idx), .div_rotate(div_rotate), .chop_sign(chop_sign)
    );

    // Vector: [15:8] ticks, [7] ext sign, [6] div enable, [5:3] chop k, [2:0] cycle N
    localparam logic [15:0] VEC [8] = '{
        {8'd10,  1'b0, 1'b1, 3'd1, 3'd1},
        {8'd25,  1'b0, 1'b1, 3'd2, 3'd3},
        {8'd30,  1'b0, 1'b0, 3'd1, 3'd7},
        {8'd40,  1'b0, 1'b1, 3'd3, 3'd2},
        {8'd12,  1'b0, 1'b1, 3'd1, 3'd0},
        {8'd17,  1'b0, 1'b1, 3'd1, 3'd5},
        {8'd130, 1'b0, 1'b0, 3'd7, 3'd1},
        {8'd20,  1'b1, 1'b1, 3'd0, 3'd4}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        div_seen = 0;
    endtask

    // One tick-high cycle then one idle cycle; div pulses counted at negedges
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            fs_tick = 1'b1;
            @(negedge clk);
            fs_tick = 1'b0;
            if (div_rotate) div_seen++;
            @(negedge clk);
            if (div_rotate) div_seen++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fs_tick = 1'b0; cyc_sel = 3'd0; div_cyc_en = 1'b0;
        chop_sel = 3'd1; ext_sign_in = 1'b0; ext_seg_en = 1'b0; ext_seg_idx = 3'd0;
        do_reset();

        // R9 reset state
        check("R9 seg", int'(seg_idx), 0);
        check("R9 sign", int'(chop_sign), 0);
        check("R9 div", int'(div_rotate), 0);

        // Vector table: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < 8; v++) begin
            int n, k, t, rots, es, ex;
            n = int'(VEC[v][2:0]);
            k = int'(VEC[v][5:3]);
            t = int'(VEC[v][15:8]);
            cyc_sel = VEC[v][2:0];
            chop_sel = VEC[v][5:3];
            div_cyc_en = VEC[v][6];
            ext_sign_in = VEC[v][7];
            do_reset();
            tick(t);
            rots = (n == 0) ? 0 : t / n;
            es = (k == 0) ? int'(VEC[v][7]) : ((rots >> k) & 1);
            ex = VEC[v][6] ? rots : 0;
            check($sformatf("R2/R3 vec%0d seg", v), int'(seg_idx), rots % 8);
            check($sformatf("R5/R6 vec%0d sign", v), int'(chop_sign), es);
            check($sformatf("R4/R1 vec%0d div pulses", v), div_seen, ex);
        end

        // R3 wrap at edge: N=1, 7 ticks -> 7, one more -> 0
        cyc_sel = 3'd1; chop_sel = 3'd3; div_cyc_en = 1'b1;
        do_reset();
        tick(7);
        check("R3 seg before wrap", int'(seg_idx), 7);
        tick(1);
        check("R3 seg after wrap", int'(seg_idx), 0);

        // R2 update timing: N=2, first tick no advance, second tick advances right after edge
        cyc_sel = 3'd2; do_reset();
        fs_tick = 1'b1; @(negedge clk); fs_tick = 1'b0;
        check("R2 no advance after 1 of 2", int'(seg_idx), 0);
        @(negedge clk);
        fs_tick = 1'b1; @(negedge clk); fs_tick = 1'b0;
        check("R2 advance after 2 of 2", int'(seg_idx), 1);
        check("R4 pulse same cycle", int'(div_rotate), 1);
        @(negedge clk);
        check("R4 pulse one cycle", int'(div_rotate), 0);

        // R7 chop sign holds while N=0
        cyc_sel = 3'd1; chop_sel = 3'd1; do_reset();
        tick(2);
        check("R7 sign set", int'(chop_sign), 1);
        cyc_sel = 3'd0;
        tick(10);
        check("R7 sign held", int'(chop_sign), 1);
        check("R1 seg held", int'(seg_idx), 2);

        // R6 external sign passes through; internal sign kept
        chop_sel = 3'd0; ext_sign_in = 1'b0; #1;
        check("R6 ext 0", int'(chop_sign), 0);
        ext_sign_in = 1'b1; #1;
        check("R6 ext 1", int'(chop_sign), 1);
        ext_sign_in = 1'b0; cyc_sel = 3'd1;
        tick(4);
        chop_sel = 3'd1; #1;
        check("R6 internal sign kept", int'(chop_sign), 1);

        // R8 forced index, internal keeps counting
        cyc_sel = 3'd1; chop_sel = 3'd2; do_reset();
        tick(1);
        ext_seg_en = 1'b1; ext_seg_idx = 3'd5; #1;
        check("R8 forced", int'(seg_idx), 5);
        tick(2);
        check("R8 forced during ticks", int'(seg_idx), 5);
        ext_seg_en = 1'b0; #1;
        check("R8 internal resumed", int'(seg_idx), 3);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule